// File: doc/BRIEF.md
# Flash Unlock Command Sequence Decoder

This block is the synchronous command front end of a dual-bank NOR flash. It watches one-cycle write strobes that carry a 20-bit word address and a 16-bit data word. It recognises the unlock-protected command sequences, and when a sequence completes it raises a single-cycle request for the program/erase engine or for the mode logic. Every request carries the target address and data that were captured with it.

The decoder also keeps the current read mode: array, identification or query. In identification mode it returns the manufacturer and device words when the read address points at them. A busy input from the status block freezes the decoder completely. A write-protect input, active low, shields the four lowest 1K-word sectors from program and erase.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset `reqValid` is 0, `reqOp` is 0 (none), `reqSkipProt` is 0 and `readMode` is 0 (array).
- R2: Each sequence opens with two unlock writes: low data byte AAh at address 5555h, then low data byte 55h at address 2AAAh. Only address bits 14..0 and data bits 7..0 are compared. Address bits 19..15 and data bits 15..8 have no effect.
- R3: After the unlock, a third write of A0h at 5555h arms a program. The next write sets `reqValid`=1 and `reqOp`=1 in the cycle that follows that write. It carries `reqAddr` equal to the full write address and `reqData` equal to the write data.
- R4: After the unlock, a third write of 80h at 5555h starts the erase path. That path needs AAh at 5555h and then 55h at 2AAAh. A sixth write of 10h at 5555h then gives `reqOp`=4 (chip erase) with `reqAddr`=0.
- R5: On the erase path, a sixth write of 30h at any address gives `reqOp`=2 (sector erase). Its `reqAddr` is the write address with bits 9..0 cleared, so the sector is address bits 19..10.
- R6: On the erase path, a sixth write of 50h at any address gives `reqOp`=3 (block erase). Its `reqAddr` is the write address with bits 14..0 cleared, so the block is address bits 19..15.
- R7: A third write at 5555h of 90h sets `readMode`=1 and issues `reqOp`=5. A third write of 98h sets `readMode`=2 and issues `reqOp`=6. A third write of F0h sets `readMode`=0 and issues `reqOp`=7.
- R8: When `readMode` is 1 and address bits 19..1 are zero, `idHit` is 1 and `idWord` is 00BFh for bit 0 = 0 and 2761h for bit 0 = 1. Otherwise `idHit` is 0 and `idWord` is 0.
- R9: A write that does not match the next expected cycle of a sequence drops the sequence, issues no request and sets `readMode` to 0.
- R10: While `busy` is 1, every write is ignored: sequence progress, read mode and requests all stay unchanged, and the exit command is ignored too.
- R11: When `wpN` is 0, a program, sector-erase or block-erase request whose target overlaps words 000000h..000FFFh issues no request.
- R12: A chip erase always issues its request. `reqSkipProt` is 1 with it exactly when `wpN` was 0 at the sixth write.
- R13: A request lasts exactly one cycle. In every other cycle `reqValid` is 0 and `reqOp` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrStb | input | 1 | One-cycle write strobe, already synchronised |
| busAddr | input | 20 | Word address for writes and identification reads |
| busData | input | 16 | Write data |
| busy | input | 1 | Internal write in progress; writes are ignored |
| wpN | input | 1 | Write protect of the lowest four sectors, active low |
| reqValid | output | 1 | Single-cycle request strobe |
| reqOp | output | 3 | Request kind: 1 program, 2 sector, 3 block, 4 chip, 5 ID entry, 6 query entry, 7 exit |
| reqAddr | output | 20 | Target address of the request |
| reqData | output | 16 | Data word of the closing write |
| reqSkipProt | output | 1 | Chip erase must skip the protected sectors |
| readMode | output | 2 | 0 array, 1 identification, 2 query |
| idHit | output | 1 | Identification word is being read |
| idWord | output | 16 | Identification word for `busAddr` |

## Verification
The bench sweeps every block index and a range of sector indices, each with protection on and off. A protection compare that is off by one, or that uses the block bits for sectors, would suppress the wrong targets or pass a protected one. It varies the upper address bits and the upper data byte during unlock. A decoder that compares the full address would then fail to recognise most sequences. It sends an exit sequence while busy and garbage between unlock cycles while busy. A decoder that lets busy writes through would leave identification mode early or lose a program request. It also sends wrong second, third and sixth cycles. A decoder that does not fall back to idle would fire a stale request or stay in identification mode.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  localparam int CODE_W = 8;

  typedef enum logic [2:0] {
    OP_NONE = 3'd0,
    OP_PROG = 3'd1,
    OP_SECT = 3'd2,
    OP_BLK  = 3'd3,
    OP_CHIP = 3'd4,
    OP_ID   = 3'd5,
    OP_QRY  = 3'd6,
    OP_EXIT = 3'd7
  } cmdOp_t;

  typedef enum logic [1:0] {
    MODE_ARRAY = 2'd0,
    MODE_ID    = 2'd1,
    MODE_QUERY = 2'd2
  } readMode_t;

  // strobes from the control to the datapath
  typedef struct packed {
    logic   fire;
    cmdOp_t op;
  } ctrlStrobe_t;

  // bus comparisons from the datapath to the control
  typedef struct packed {
    logic              hitUnlockA;
    logic              hitUnlockB;
    logic [CODE_W-1:0] code;
  } busMatch_t;

  localparam logic [CODE_W-1:0] CODE_UNLK1 = 8'hAA;
  localparam logic [CODE_W-1:0] CODE_UNLK2 = 8'h55;
  localparam logic [CODE_W-1:0] CODE_PROG  = 8'hA0;
  localparam logic [CODE_W-1:0] CODE_ERASE = 8'h80;
  localparam logic [CODE_W-1:0] CODE_CHIP  = 8'h10;
  localparam logic [CODE_W-1:0] CODE_SECT  = 8'h30;
  localparam logic [CODE_W-1:0] CODE_BLK   = 8'h50;
  localparam logic [CODE_W-1:0] CODE_ID    = 8'h90;
  localparam logic [CODE_W-1:0] CODE_QRY   = 8'h98;
  localparam logic [CODE_W-1:0] CODE_EXIT  = 8'hF0;

endpackage

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flash_cmd_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrStb,
  input  logic        busy,
  input  busMatch_t   match,
  output ctrlStrobe_t strobe,
  output readMode_t   readMode
);

  typedef enum logic [2:0] {
    S_IDLE,
    S_UNLK1,
    S_UNLK2,
    S_PROG,
    S_ERA3,
    S_ERA4,
    S_ERA5
  } seqState_t;

  seqState_t curState, nxtState;
  readMode_t curMode, nxtMode;
  logic      dropSeq;
  logic      takeWrite;

  assign takeWrite = wrStb && !busy;

  always_comb begin
    nxtState = curState;
    nxtMode  = curMode;
    dropSeq  = 1'b0;
    strobe   = '{fire: 1'b0, op: OP_NONE};
    if (takeWrite) begin
      unique case (curState)
        S_IDLE, S_ERA3: begin
          if (match.hitUnlockA && match.code == CODE_UNLK1)
            nxtState = (curState == S_IDLE) ? S_UNLK1 : S_ERA4;
          else
            dropSeq = 1'b1;
        end
        S_UNLK1, S_ERA4: begin
          if (match.hitUnlockB && match.code == CODE_UNLK2)
            nxtState = (curState == S_UNLK1) ? S_UNLK2 : S_ERA5;
          else
            dropSeq = 1'b1;
        end
        S_UNLK2: begin
          nxtState = S_IDLE;
          if (!match.hitUnlockA) dropSeq = 1'b1;
          else begin
            unique case (match.code)
              CODE_PROG:  nxtState = S_PROG;
              CODE_ERASE: nxtState = S_ERA3;
              CODE_ID: begin
                nxtMode = MODE_ID;
                strobe  = '{fire: 1'b1, op: OP_ID};
              end
              CODE_QRY: begin
                nxtMode = MODE_QUERY;
                strobe  = '{fire: 1'b1, op: OP_QRY};
              end
              CODE_EXIT: begin
                nxtMode = MODE_ARRAY;
                strobe  = '{fire: 1'b1, op: OP_EXIT};
              end
              default: dropSeq = 1'b1;
            endcase
          end
        end
        S_PROG: begin
          nxtState = S_IDLE;
          strobe   = '{fire: 1'b1, op: OP_PROG};
        end
        S_ERA5: begin
          nxtState = S_IDLE;
          if (match.code == CODE_SECT)
            strobe = '{fire: 1'b1, op: OP_SECT};
          else if (match.code == CODE_BLK)
            strobe = '{fire: 1'b1, op: OP_BLK};
          else if (match.code == CODE_CHIP && match.hitUnlockA)
            strobe = '{fire: 1'b1, op: OP_CHIP};
          else
            dropSeq = 1'b1;
        end
        default: dropSeq = 1'b1;
      endcase
      if (dropSeq) begin
        nxtState = S_IDLE;
        nxtMode  = MODE_ARRAY;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curState <= S_IDLE;
      curMode  <= MODE_ARRAY;
    end else begin
      curState <= nxtState;
      curMode  <= nxtMode;
    end
  end

  assign readMode = curMode;

  // R10: a busy cycle leaves sequence progress and mode untouched
  p_busy_freeze_r10: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> ($stable(curState) && $stable(curMode)));

  // R10: no request can come out of an ignored write
  p_fire_needs_write_r10: assert property (@(posedge clk) disable iff (!rstN)
    strobe.fire |-> (wrStb && !busy));

endmodule

// File: rtl/flash_cmd_dp.sv
module flash_cmd_dp
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W     = 20,
  parameter int DATA_W     = 16,
  parameter int CMP_W      = 15,
  parameter int SECT_LSB   = 10,
  parameter int BLK_LSB    = 15,
  parameter int PROT_SECTS = 4,
  parameter logic [CMP_W-1:0]  UNLOCK_A = 15'h5555,
  parameter logic [CMP_W-1:0]  UNLOCK_B = 15'h2AAA,
  parameter logic [DATA_W-1:0] ID_MFR   = 16'h00BF,
  parameter logic [DATA_W-1:0] ID_DEV   = 16'h2761
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busData,
  input  logic              wpN,
  input  ctrlStrobe_t       strobe,
  input  readMode_t         readMode,
  output busMatch_t         match,
  output logic              reqValid,
  output cmdOp_t            reqOp,
  output logic [ADDR_W-1:0] reqAddr,
  output logic [DATA_W-1:0] reqData,
  output logic              reqSkipProt,
  output logic              idHit,
  output logic [DATA_W-1:0] idWord
);

  localparam int SECT_W     = ADDR_W - SECT_LSB;
  localparam int BLK_W      = ADDR_W - BLK_LSB;
  localparam int PROT_WORDS = PROT_SECTS << SECT_LSB;
  localparam int PROT_BLKS  = (PROT_WORDS + (1 << BLK_LSB) - 1) >> BLK_LSB;
  localparam logic [SECT_W-1:0] SECT_LIM = SECT_W'(PROT_SECTS);
  localparam logic [BLK_W-1:0]  BLK_LIM  = BLK_W'(PROT_BLKS);

  logic [SECT_W-1:0] sectIdx;
  logic [BLK_W-1:0]  blkIdx;
  logic              sectProt, blkProt, suppress, wpOn;
  logic [ADDR_W-1:0] tgtAddr;

  assign match.hitUnlockA = (busAddr[CMP_W-1:0] == UNLOCK_A);
  assign match.hitUnlockB = (busAddr[CMP_W-1:0] == UNLOCK_B);
  assign match.code       = busData[CODE_W-1:0];

  assign sectIdx = busAddr[ADDR_W-1:SECT_LSB];
  assign blkIdx  = busAddr[ADDR_W-1:BLK_LSB];

  generate
    if (PROT_SECTS > 0) begin : g_prot
      assign sectProt = (sectIdx < SECT_LIM);
      assign blkProt  = (blkIdx < BLK_LIM);
      assign wpOn     = !wpN;
    end else begin : g_noprot
      assign sectProt = 1'b0;
      assign blkProt  = 1'b0;
      assign wpOn     = 1'b0;
    end
  endgenerate

  always_comb begin
    unique case (strobe.op)
      OP_PROG, OP_SECT: suppress = wpOn && sectProt;
      OP_BLK:           suppress = wpOn && blkProt;
      default:          suppress = 1'b0;
    endcase
  end

  always_comb begin
    unique case (strobe.op)
      OP_SECT: tgtAddr = {sectIdx, {SECT_LSB{1'b0}}};
      OP_BLK:  tgtAddr = {blkIdx, {BLK_LSB{1'b0}}};
      OP_CHIP: tgtAddr = '0;
      default: tgtAddr = busAddr;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqValid    <= 1'b0;
      reqOp       <= OP_NONE;
      reqAddr     <= '0;
      reqData     <= '0;
      reqSkipProt <= 1'b0;
    end else begin
      reqValid    <= strobe.fire && !suppress;
      reqOp       <= (strobe.fire && !suppress) ? strobe.op : OP_NONE;
      reqSkipProt <= strobe.fire && (strobe.op == OP_CHIP) && wpOn;
      if (strobe.fire) begin
        reqAddr <= tgtAddr;
        reqData <= busData;
      end
    end
  end

  assign idHit  = (readMode == MODE_ID) && (busAddr[ADDR_W-1:1] == '0);
  assign idWord = idHit ? (busAddr[0] ? ID_DEV : ID_MFR) : '0;

  // R13: requests never last two cycles
  p_single_pulse_r13: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> !reqValid);

  // R11: a request into the protected sectors needs protection released
  p_prot_guard_r11: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && (reqOp == OP_PROG || reqOp == OP_SECT) &&
     (reqAddr[ADDR_W-1:SECT_LSB] < SECT_LIM)) |-> $past(wpN));

  // R12: the skip flag only rides on a chip erase
  p_skip_only_chip_r12: assert property (@(posedge clk) disable iff (!rstN)
    reqSkipProt |-> (reqValid && reqOp == OP_CHIP));

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W     = 20,
  parameter int DATA_W     = 16,
  parameter int CMP_W      = 15,
  parameter int SECT_LSB   = 10,
  parameter int BLK_LSB    = 15,
  parameter int PROT_SECTS = 4
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrStb,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busData,
  input  logic              busy,
  input  logic              wpN,
  output logic              reqValid,
  output logic [2:0]        reqOp,
  output logic [ADDR_W-1:0] reqAddr,
  output logic [DATA_W-1:0] reqData,
  output logic              reqSkipProt,
  output logic [1:0]        readMode,
  output logic              idHit,
  output logic [DATA_W-1:0] idWord
);

  ctrlStrobe_t strobe;
  busMatch_t   match;
  readMode_t   modeNow;
  cmdOp_t      opNow;

  flash_cmd_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .wrStb    (wrStb),
    .busy     (busy),
    .match    (match),
    .strobe   (strobe),
    .readMode (modeNow)
  );

  flash_cmd_dp #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .CMP_W      (CMP_W),
    .SECT_LSB   (SECT_LSB),
    .BLK_LSB    (BLK_LSB),
    .PROT_SECTS (PROT_SECTS)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .busAddr     (busAddr),
    .busData     (busData),
    .wpN         (wpN),
    .strobe      (strobe),
    .readMode    (modeNow),
    .match       (match),
    .reqValid    (reqValid),
    .reqOp       (opNow),
    .reqAddr     (reqAddr),
    .reqData     (reqData),
    .reqSkipProt (reqSkipProt),
    .idHit       (idHit),
    .idWord      (idWord)
  );

  assign reqOp    = opNow;
  assign readMode = modeNow;

  // R3: every request follows an accepted write strobe
  p_req_after_write_r3: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> $past(wrStb));

endmodule

// File: tb/flash_cmd_decoder_test.sv
module flash_cmd_decoder_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrStb = 1'b0;
  logic [19:0] busAddr = '0;
  logic [15:0] busData = '0;
  logic        busy = 1'b0;
  logic        wpN = 1'b1;
  logic        reqValid, reqSkipProt, idHit;
  logic [2:0]  reqOp;
  logic [19:0] reqAddr;
  logic [15:0] reqData, idWord;
  logic [1:0]  readMode;

  int nChk = 0;
  int nBad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  flash_cmd_decoder uut (
    .clk(clk), .rstN(rstN), .wrStb(wrStb), .busAddr(busAddr),
    .busData(busData), .busy(busy), .wpN(wpN), .reqValid(reqValid),
    .reqOp(reqOp), .reqAddr(reqAddr), .reqData(reqData),
    .reqSkipProt(reqSkipProt), .readMode(readMode), .idHit(idHit),
    .idWord(idWord)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // returns at the falling edge after the capturing edge
  task automatic wr(input logic [19:0] a, input logic [15:0] d);
    @(negedge clk);
    busAddr = a; busData = d; wrStb = 1'b1;
    @(negedge clk);
    wrStb = 1'b0;
  endtask

  task automatic unlock(input logic [4:0] hi, input logic [7:0] hd);
    wr({hi, 15'h5555}, {hd, 8'hAA});
    wr({hi, 15'h2AAA}, {hd, 8'h55});
  endtask

  task automatic erase(input logic [4:0] hi, input logic [19:0] a, input logic [7:0] code);
    unlock(hi, 8'h3C);
    wr({hi, 15'h5555}, 16'hC380);
    unlock(~hi, 8'hC3);
    wr(a, {8'h7E, code});
  endtask

  task automatic expReq(input string req, input logic [2:0] op,
                        input logic [19:0] a, input logic [15:0] d, input logic skip);
    check(req, {31'd0, reqValid}, 32'd1);
    check(req, {29'd0, reqOp}, {29'd0, op});
    check(req, {12'd0, reqAddr}, {12'd0, a});
    check(req, {16'd0, reqData}, {16'd0, d});
    check(req, {31'd0, reqSkipProt}, {31'd0, skip});
  endtask

  task automatic expNone(input string req);
    check(req, {31'd0, reqValid}, 32'd0);
    check(req, {29'd0, reqOp}, 32'd0);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      nChk++; nBad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 valid", {31'd0, reqValid}, 0);
    check("R1 op", {29'd0, reqOp}, 0);
    check("R1 skip", {31'd0, reqSkipProt}, 0);
    check("R1 mode", {30'd0, readMode}, 0);
    rstN = 1'b1;

    // R2 R3 R13: program sweep with don't-care high address and data bits
    for (int i = 0; i < 16; i++) begin
      logic [19:0] a;
      logic [15:0] d;
      a = 20'h01000 + 20'(i * 20'h0F1A3);
      d = 16'(i * 16'h1357 + 3);
      wpN = 1'b1;
      unlock(5'(i * 3), 8'(i * 17));
      wr({5'(i), 15'h5555}, {8'(i), 8'hA0});
      wr(a, d);
      expReq("R3 program", 3'd1, a, d, 1'b0);
      @(negedge clk);
      expNone("R13 one-cycle request");
    end

    // R11: program against the protected range
    for (int i = 0; i < 12; i++) begin
      logic [19:0] a;
      a = 20'(i * 20'h00203);
      for (int w = 0; w < 2; w++) begin
        wpN = w[0];
        unlock(5'd0, 8'd0);
        wr(20'h05555, 16'h00A0);
        wr(a, 16'hBEEF);
        if (w == 1 || a >= 20'h01000) expReq("R11 program allowed", 3'd1, a, 16'hBEEF, 1'b0);
        else expNone("R11 program suppressed");
      end
    end

    // R5 R11: sector erase
    for (int s = 0; s < 10; s++) begin
      logic [9:0] sec;
      sec = (s < 8) ? 10'(s) : 10'(1023 - s);
      for (int w = 0; w < 2; w++) begin
        wpN = w[0];
        erase(5'(s), {sec, 10'h155}, 8'h30);
        if (w == 1 || sec >= 10'd4) expReq("R5 sector erase", 3'd2, {sec, 10'd0}, 16'h7E30, 1'b0);
        else expNone("R11 sector suppressed");
      end
    end

    // R6 R11: block erase over every block
    for (int b = 0; b < 32; b++) begin
      for (int w = 0; w < 2; w++) begin
        wpN = w[0];
        erase(5'(b), {5'(b), 15'h1234}, 8'h50);
        if (w == 1 || b != 0) expReq("R6 block erase", 3'd3, {5'(b), 15'd0}, 16'h7E50, 1'b0);
        else expNone("R11 block suppressed");
      end
    end

    // R4 R12: chip erase
    for (int w = 0; w < 2; w++) begin
      wpN = w[0];
      erase(5'd9, {5'd9, 15'h5555}, 8'h10);
      expReq("R12 chip erase", 3'd4, 20'd0, 16'h7E10, ~w[0]);
    end
    wpN = 1'b1;
    // R4: chip code away from 5555h aborts
    erase(5'd0, 20'h01234, 8'h10);
    expNone("R4 chip erase needs 5555h");
    // R9: invalid sixth code
    erase(5'd0, 20'h05555, 8'h20);
    expNone("R9 bad sixth cycle");
    // R9: wrong third code
    unlock(5'd0, 8'd0);
    wr(20'h05555, 16'h0077);
    expNone("R9 bad third cycle");

    // R7 R8: identification mode and reads
    unlock(5'd2, 8'd0);
    wr(20'h15555, 16'h0090);
    expReq("R7 id entry", 3'd5, 20'h15555, 16'h0090, 1'b0);
    check("R7 id mode", {30'd0, readMode}, 1);
    for (int k = 0; k < 8; k++) begin
      logic [19:0] a;
      logic        hit;
      a = (k < 4) ? 20'(k) : (20'h80000 | 20'(k - 4));
      @(negedge clk);
      busAddr = a;
      #1;
      hit = (a[19:1] == 19'd0);
      check("R8 id hit", {31'd0, idHit}, {31'd0, hit});
      check("R8 id word", {16'd0, idWord}, hit ? (a[0] ? 32'h2761 : 32'h00BF) : 32'd0);
    end

    // R10: exit while busy is ignored
    @(negedge clk);
    busy = 1'b1;
    unlock(5'd0, 8'd0);
    wr(20'h05555, 16'h00F0);
    expNone("R10 busy exit no request");
    check("R10 busy exit mode kept", {30'd0, readMode}, 1);
    busy = 1'b0;

    // R9: broken second cycle leaves id mode
    wr(20'h05555, 16'h00AA);
    wr(20'h02AAB, 16'h0055);
    expNone("R9 abort request");
    check("R9 abort mode", {30'd0, readMode}, 0);

    // R7: query then exit
    unlock(5'd0, 8'd0);
    wr(20'h05555, 16'h0098);
    expReq("R7 query entry", 3'd6, 20'h05555, 16'h0098, 1'b0);
    check("R7 query mode", {30'd0, readMode}, 2);
    busAddr = 20'd0;
    #1 check("R8 no id in query", {31'd0, idHit}, 0);
    unlock(5'd0, 8'd0);
    wr(20'h05555, 16'h00F0);
    expReq("R7 exit", 3'd7, 20'h05555, 16'h00F0, 1'b0);
    check("R7 exit mode", {30'd0, readMode}, 0);

    // R10: busy garbage mid-sequence keeps progress
    wr(20'h05555, 16'h00AA);
    busy = 1'b1;
    wr(20'h01111, 16'h1234);
    expNone("R10 busy write no request");
    busy = 1'b0;
    wr(20'h02AAA, 16'h0055);
    wr(20'h05555, 16'h00A0);
    wr(20'h4ABCD, 16'h5A5A);
    expReq("R10 sequence survives busy", 3'd1, 20'h4ABCD, 16'h5A5A, 1'b0);

    // R2: full address compare would miss this (upper bits set)
    unlock(5'h1F, 8'hFF);
    wr(20'hFD555, 16'hFFA0);
    wr(20'h12345, 16'h0F0F);
    expReq("R2 high bits ignored", 3'd1, 20'h12345, 16'h0F0F, 1'b0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

endmodule